// File: doc/BRIEF.md
# Always-On Register Watchdog Timer

This block is a watchdog timer that software sees as one 8-bit read/write register on a simple processor bus. The register holds a 6-bit down-counter, a software-reset control bit and an activation bit. Each pulse on the prescaler tick input lowers the counter by one. When the counter runs out, the block drives a system reset pulse of fixed length. It drives the same pulse at once when software writes the software-reset bit as zero.

Software keeps the system alive by writing a fresh count into the register before the count runs out. The counter field is stored with its significance reversed: the highest bus bit carries the counter's least significant bit. Writes and reads both use this reversed order. The activation bit reads back as written, but it has no control over the timer, so the timer can never be stopped. After the power-on reset and after every pulse, the register holds FEh.

Top module: `wdt_always_on`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `rdata` reads 8'hFE and `sys_rst` is low.
- R2: A write with `wdata[1]`=1 loads the counter from bits 7..2 in reversed order. Bit 7 is counter bit 0 and bit 2 is counter bit 5, so writing 8'h82 loads a count of 1.
- R3: `rdata` is the counter in the same reversed order on bits 7..2, the software-reset bit on bit 1 and the activation bit on bit 0. It reflects a write one clock after that write.
- R4: Each clock with `tick` high and no write lowers a counter above 1 by exactly one.
- R5: A tick that finds the counter at 1 or 0 raises `sys_rst` after that clock edge. `sys_rst` then stays high for exactly PULSE_LEN clocks.
- R6: A write with `wdata[1]`=0 raises `sys_rst` after that clock edge for exactly PULSE_LEN clocks, whatever the other data bits hold.
- R7: The activation bit (bit 0) is stored and reads back as written, but it has no effect: the counter keeps decrementing and timing out whether it is 0 or 1.
- R8: When `sys_rst` falls, `rdata` reads 8'hFE.
- R9: Rewriting the count before it reaches a timeout tick keeps `sys_rst` low for as long as the rewrites continue.
- R10: When a write and a tick arrive in the same clock, the write wins. The counter takes the written value with no decrement.
- R11: While `sys_rst` is high, `rdata` stays 8'hFE. Writes and ticks are ignored and do not change the pulse length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | Prescaler tick, one clock wide per count step |
| we | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Current register contents |
| sys_rst | output | 1 | System reset pulse, active high |

## Verification
A counter that holds the wrong value or the wrong bit order shows up on `rdata` one clock after the write or tick that set it. The reversed field layout makes a swapped mapping visible at once, unless the count is a palindrome. A wrong timeout decision or a wrong pulse-length state shows on `sys_rst` at the first edge after the deciding tick or write, or at the edge where the pulse should end. A pulse that ignores held-off writes or ticks only shows through `rdata` and the pulse length while the pulse is active.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
    localparam int unsigned CNT_W   = 6;
    localparam int unsigned REG_W   = CNT_W + 2;
    localparam int unsigned SR_POS  = 1;
    localparam int unsigned ACT_POS = 0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sr;
        logic             act;
    } wdr_state_t;

    localparam wdr_state_t WDR_RST_VAL = '{cnt: '1, sr: 1'b1, act: 1'b0};
endpackage

// File: rtl/wdr_field_swap.sv
module wdr_field_swap #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_swap
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/wdr_pulse_gen.sv
module wdr_pulse_gen #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (left_q != '0) begin
            left_d = left_q - CW'(1);
        end else if (start) begin
            left_d = CW'(LEN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/wdt_always_on.sv
module wdt_always_on #(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     we,
    input  logic [wdr_pkg::REG_W-1:0] wdata,
    output logic [wdr_pkg::REG_W-1:0] rdata,
    output logic                     sys_rst
);
    localparam int unsigned CW = wdr_pkg::CNT_W;

    wdr_pkg::wdr_state_t st_d, st_q;
    logic [CW-1:0] wr_cnt, rd_field;
    logic          busy, fire_sw, fire_to;

    wdr_field_swap #(.W(CW)) i_wr_swap (
        .din  (wdata[wdr_pkg::REG_W-1:2]),
        .dout (wr_cnt)
    );

    wdr_field_swap #(.W(CW)) i_rd_swap (
        .din  (st_q.cnt),
        .dout (rd_field)
    );

    wdr_pulse_gen #(.LEN(PULSE_LEN)) i_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fire_sw | fire_to),
        .active (busy)
    );

    always_comb begin
        st_d    = st_q;
        fire_sw = 1'b0;
        fire_to = 1'b0;
        if (busy) begin
            st_d = wdr_pkg::WDR_RST_VAL;
        end else if (we) begin
            if (!wdata[wdr_pkg::SR_POS]) begin
                fire_sw = 1'b1;
                st_d    = wdr_pkg::WDR_RST_VAL;
            end else begin
                st_d.cnt = wr_cnt;
                st_d.sr  = 1'b1;
                st_d.act = wdata[wdr_pkg::ACT_POS];
            end
        end else if (tick) begin
            if (st_q.cnt[CW-1:1] == '0) begin
                fire_to = 1'b1;
                st_d    = wdr_pkg::WDR_RST_VAL;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= wdr_pkg::WDR_RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = {rd_field, st_q.sr, st_q.act};
    assign sys_rst = busy;
endmodule

// File: rtl/wdt_always_on_chk.sv
module wdt_always_on_chk #(
    parameter int unsigned PULSE_LEN = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic                     we,
    input logic [wdr_pkg::REG_W-1:0] wdata,
    input logic [wdr_pkg::REG_W-1:0] rdata,
    input logic                     sys_rst
);
    localparam int unsigned CW = wdr_pkg::CNT_W;

    function automatic logic [CW-1:0] field_to_cnt(input logic [wdr_pkg::REG_W-1:0] b);
        logic [CW-1:0] r;
        for (int i = 0; i < int'(CW); i++) r[i] = b[wdr_pkg::REG_W-1-i];
        return r;
    endfunction

    logic [CW-1:0] cnt_now;
    logic [7:0]    hi_run;
    assign cnt_now = field_to_cnt(rdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_run <= '0;
        else if (sys_rst) hi_run <= hi_run + 8'd1;
        else hi_run <= '0;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[wdr_pkg::SR_POS] && !sys_rst) |=> (rdata == $past(wdata)));

    p_decr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !we && !sys_rst && cnt_now > 1) |=> (cnt_now == $past(cnt_now) - 1));

    p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !we && !sys_rst && cnt_now <= 1) |=> sys_rst);

    p_sw_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[wdr_pkg::SR_POS] && !sys_rst) |=> sys_rst);

    p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= 8'(PULSE_LEN));

    p_pulse_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (hi_run == 8'(PULSE_LEN)));

    p_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (rdata == 8'hFE));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (rdata == 8'hFE));
endmodule

bind wdt_always_on wdt_always_on_chk #(.PULSE_LEN(PULSE_LEN)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .we      (we),
    .wdata   (wdata),
    .rdata   (rdata),
    .sys_rst (sys_rst)
);

// File: tb/test_wdt_always_on.sv
module test_wdt_always_on;
    localparam int unsigned PL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sys_rst;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    wdt_always_on #(.PULSE_LEN(PL)) i_wdt_always_on (
        .clk(clk), .rst_n(rst_n), .tick(tick), .we(we),
        .wdata(wdata), .rdata(rdata), .sys_rst(sys_rst)
    );

    function automatic logic [7:0] enc(input int v, input logic sr, input logic c);
        logic [7:0] b;
        for (int i = 0; i < 6; i++) b[7-i] = v[i];
        b[1] = sr;
        b[0] = c;
        return b;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [7:0] d, input logic t);
        @(negedge clk);
        we = w; wdata = d; tick = t;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse_check(input string req, input logic poke);
        for (int i = 0; i < int'(PL); i++) begin
            chk(req, {7'd0, sys_rst}, 8'd1);
            chk("R11", rdata, 8'hFE);
            if (poke) begin we = 1'b1; wdata = enc(9, 1'b1, 1'b1); tick = 1'b1; end
            @(negedge clk);
        end
        we = 1'b0; tick = 1'b0;
        chk(req, {7'd0, sys_rst}, 8'd0);
        chk("R8", rdata, 8'hFE);
    endtask

    task automatic t_reset;
        chk("R1", rdata, 8'hFE);
        chk("R1", {7'd0, sys_rst}, 8'd0);
    endtask

    task automatic t_load;
        cyc(1'b1, enc(37, 1'b1, 1'b0), 1'b0);
        chk("R2", rdata, enc(37, 1'b1, 1'b0));
        cyc(1'b1, 8'h82, 1'b0);
        chk("R3", rdata, 8'h82);
        cyc(1'b1, enc(48, 1'b1, 1'b0), 1'b0);
        chk("R3", rdata, 8'h0E);
    endtask

    task automatic t_tick;
        cyc(1'b1, enc(20, 1'b1, 1'b0), 1'b0);
        for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b1);
        chk("R4", rdata, enc(17, 1'b1, 1'b0));
    endtask

    task automatic t_act_bit;
        cyc(1'b1, enc(5, 1'b1, 1'b1), 1'b0);
        chk("R7", rdata, enc(5, 1'b1, 1'b1));
        cyc(1'b0, 8'h00, 1'b1);
        chk("R7", rdata, enc(4, 1'b1, 1'b1));
        cyc(1'b1, enc(1, 1'b1, 1'b0), 1'b0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        pulse_check("R7", 1'b0);
    endtask

    task automatic t_same_cycle;
        cyc(1'b1, enc(30, 1'b1, 1'b0), 1'b0);
        cyc(1'b1, enc(10, 1'b1, 1'b0), 1'b1);
        chk("R10", rdata, enc(10, 1'b1, 1'b0));
    endtask

    task automatic t_keepalive;
        logic seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1, enc(2, 1'b1, 1'b0), 1'b0);
            cyc(1'b0, 8'h00, 1'b1);
            if (sys_rst) seen = 1'b1;
        end
        chk("R9", {7'd0, seen}, 8'd0);
        chk("R9", rdata, enc(1, 1'b1, 1'b0));
    endtask

    task automatic t_timeout_one;
        cyc(1'b1, 8'h82, 1'b0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        pulse_check("R5", 1'b1);
    endtask

    task automatic t_timeout_zero;
        cyc(1'b1, 8'h02, 1'b0);
        chk("R5", rdata, 8'h02);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        pulse_check("R5", 1'b0);
    endtask

    task automatic t_sw_reset;
        cyc(1'b1, enc(25, 1'b1, 1'b1), 1'b0);
        @(negedge clk); we = 1'b1; wdata = 8'hA5 & 8'hFD;
        @(negedge clk); we = 1'b0;
        pulse_check("R6", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_tick();
        t_act_bit();
        t_same_cycle();
        t_keepalive();
        t_timeout_one();
        t_timeout_zero();
        t_sw_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule